// File: doc/BRIEF.md
# Single-Channel Bus-Master DMA Engine

This block moves a block of words between one peripheral data port and a plain memory bus, so the processor does not copy each word itself. Software sets up a transfer through a small register port. It writes a direction, a device identifier, a starting memory word address and a word count, then writes a go command. The engine then requests the system bus with a request/grant handshake. It moves exactly one word on each cycle in which it holds the bus and the grant is high. It steps the address up and the count down on every word.

A mode bit sets how long the engine keeps the bus. In block mode it holds the request from the first word to the last, so the processor is locked out for the whole block. In cycle-stealing mode it drops the request after every word and asks again, which lets the processor run between words. When the last word has moved, a sticky completion flag is set. The interrupt line is that flag gated by an enable bit. The arbiter outside the block is expected to favour the engine's request over the processor's.

Register map (word offsets on `cfg_addr`): 0 control, 1 device identifier (low 8 bits), 2 memory address, 3 word count, 4 status. The control bits are: bit 0 go, bit 1 direction (0 = memory to device, 1 = device to memory), bit 2 cycle-stealing mode (0 = block mode), bit 3 interrupt enable. The status bits are: bit 0 busy, bit 1 done. Reads of the address and count registers return the live working values.

Top module: `dma_engine`

## Requirements
- R1: After reset, status reads 0, `irq`, `bus_req`, `mem_en`, `dev_rd` and `dev_wr` are 0. When idle, the device, address and count registers read back the last value written.
- R2: A go command with a nonzero count raises `bus_req` on the next cycle. No memory or device access occurs in any cycle where `bus_grant` or `bus_req` is low.
- R3: Each moved word is one cycle with `mem_en` high. After it, the address register is one higher and the count register is one lower.
- R4: With direction 0, each word is read from memory at `mem_addr` and presented on `dev_wdata` with `dev_wr` high. With direction 1, the word on `dev_rdata` is taken with `dev_rd` high and written to memory with `mem_we` high.
- R5: In block mode, `bus_req` stays high across the whole block, words move on consecutive granted cycles, and `bus_req` is low in the cycle after the last word.
- R6: In cycle-stealing mode, `bus_req` is low in the cycle after every word and is raised again in the following cycle while words remain.
- R7: After the last word, status shows done=1 and busy=0, and `irq` is 1 when the interrupt enable bit is set and 0 when it is clear.
- R8: The done bit clears after a status read and after an accepted go command.
- R9: While busy, writes to the control, device, address and count registers are ignored, including a second go command.
- R10: A go command with a count of 0 sets done on the next cycle without ever raising `bus_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Register port access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| dev_id | output | IDW | Selected device identifier |
| dev_rd | output | 1 | Take one word from the device |
| dev_wr | output | 1 | Give one word to the device |
| dev_wdata | output | DW | Data to the device |
| dev_rdata | input | DW | Data from the device, same cycle |

## Verification
The assertions assume the grant is never high for the engine unless it was requested. They also assume that memory and the device answer in the same cycle as the strobe, with no wait states. The bench keeps to this by making the grant a registered copy of `bus_req`, which can be held low on purpose. Its memory and device models answer combinationally. Register accesses are single-cycle strobes driven on the falling edge, so the go command and the address, count and status accesses never overlap.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_ACTIVE = 2'd1,
        XS_GAP    = 2'd2
    } xfer_state_e;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_DEV    = 3'd1;
    localparam logic [2:0] RA_ADDR   = 3'd2;
    localparam logic [2:0] RA_COUNT  = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;

    localparam int CB_GO    = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_STEAL = 2;
    localparam int CB_IRQEN = 3;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int IDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_sel,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           busy,
    input  logic           fin,
    input  logic [AW-1:0]  cur_addr,
    input  logic [CW-1:0]  cur_count,
    output logic           start_go,
    output logic           ld_addr,
    output logic           ld_count,
    output logic           dir,
    output logic           steal,
    output logic           irq_en,
    output logic [IDW-1:0] dev_id,
    output logic           done
);
    typedef struct packed {
        logic           dir;
        logic           steal;
        logic           irq_en;
        logic [IDW-1:0] dev_id;
        logic           done;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_idle, rd_any;

    always_comb begin
        r_d      = r_q;
        wr_idle  = cfg_sel && cfg_we && !busy;
        rd_any   = cfg_sel && !cfg_we;
        start_go = wr_idle && (cfg_addr == RA_CTRL) && cfg_wdata[CB_GO];
        ld_addr  = wr_idle && (cfg_addr == RA_ADDR);
        ld_count = wr_idle && (cfg_addr == RA_COUNT);

        if (wr_idle && cfg_addr == RA_CTRL) begin
            r_d.dir    = cfg_wdata[CB_DIR];
            r_d.steal  = cfg_wdata[CB_STEAL];
            r_d.irq_en = cfg_wdata[CB_IRQEN];
        end
        if (wr_idle && cfg_addr == RA_DEV)
            r_d.dev_id = cfg_wdata[IDW-1:0];

        if (fin)
            r_d.done = 1'b1;
        else if (start_go || (rd_any && cfg_addr == RA_STATUS))
            r_d.done = 1'b0;

        cfg_rdata = '0;
        case (cfg_addr)
            RA_CTRL: begin
                cfg_rdata[CB_DIR]   = r_q.dir;
                cfg_rdata[CB_STEAL] = r_q.steal;
                cfg_rdata[CB_IRQEN] = r_q.irq_en;
            end
            RA_DEV:   cfg_rdata[IDW-1:0] = r_q.dev_id;
            RA_ADDR:  cfg_rdata[AW-1:0]  = cur_addr;
            RA_COUNT: cfg_rdata[CW-1:0]  = cur_count;
            RA_STATUS: begin
                cfg_rdata[SB_BUSY] = busy;
                cfg_rdata[SB_DONE] = r_q.done;
            end
            default: cfg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir    = r_q.dir;
    assign steal  = r_q.steal;
    assign irq_en = r_q.irq_en;
    assign dev_id = r_q.dev_id;
    assign done   = r_q.done;
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic          ld_addr,
    input  logic          ld_count,
    input  logic [DW-1:0] wdata,
    input  logic          steal,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic          busy,
    output logic          fin,
    output logic          move,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count
);
    localparam logic [CW-1:0] ONE_WORD = CW'(1);

    typedef struct packed {
        xfer_state_e   st;
        logic [AW-1:0] addr;
        logic [CW-1:0] count;
    } xfer_t;

    xfer_t x_d, x_q;

    always_comb begin
        x_d  = x_q;
        fin  = 1'b0;
        move = 1'b0;
        case (x_q.st)
            XS_IDLE: begin
                if (ld_addr)  x_d.addr  = wdata[AW-1:0];
                if (ld_count) x_d.count = wdata[CW-1:0];
                if (start_go) begin
                    if (x_q.count == '0) fin = 1'b1;
                    else                 x_d.st = XS_ACTIVE;
                end
            end
            XS_ACTIVE: begin
                if (bus_grant) begin
                    move      = 1'b1;
                    x_d.addr  = x_q.addr + 1'b1;
                    x_d.count = x_q.count - 1'b1;
                    if (x_q.count == ONE_WORD) begin
                        fin    = 1'b1;
                        x_d.st = XS_IDLE;
                    end else if (steal) begin
                        x_d.st = XS_GAP;
                    end
                end
            end
            XS_GAP:  x_d.st = XS_ACTIVE;
            default: x_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '{st: XS_IDLE, addr: '0, count: '0};
        else        x_q <= x_d;
    end

    assign bus_req   = (x_q.st == XS_ACTIVE);
    assign busy      = (x_q.st != XS_IDLE);
    assign cur_addr  = x_q.addr;
    assign cur_count = x_q.count;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int IDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_sel,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           irq,
    output logic           bus_req,
    input  logic           bus_grant,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [IDW-1:0] dev_id,
    output logic           dev_rd,
    output logic           dev_wr,
    output logic [DW-1:0]  dev_wdata,
    input  logic [DW-1:0]  dev_rdata
);
    logic          start_go, ld_addr, ld_count;
    logic          dir_w, steal_w, irq_en_w, done_w;
    logic          busy_w, fin_w, move_w;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW), .IDW(IDW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy_w),
        .fin       (fin_w),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .start_go  (start_go),
        .ld_addr   (ld_addr),
        .ld_count  (ld_count),
        .dir       (dir_w),
        .steal     (steal_w),
        .irq_en    (irq_en_w),
        .dev_id    (dev_id),
        .done      (done_w)
    );

    dma_xfer #(.DW(DW), .AW(AW), .CW(CW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .ld_addr   (ld_addr),
        .ld_count  (ld_count),
        .wdata     (cfg_wdata),
        .steal     (steal_w),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .busy      (busy_w),
        .fin       (fin_w),
        .move      (move_w),
        .cur_addr  (cur_addr),
        .cur_count (cur_count)
    );

    assign irq       = done_w && irq_en_w;
    assign mem_en    = move_w;
    assign mem_we    = move_w && dir_w;
    assign mem_addr  = cur_addr;
    assign mem_wdata = dev_rdata;
    assign dev_rd    = move_w && dir_w;
    assign dev_wr    = move_w && !dir_w;
    assign dev_wdata = mem_rdata;
endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          mem_en,
    input logic [AW-1:0] mem_addr,
    input logic [CW-1:0] cnt,
    input logic          steal,
    input logic          done,
    input logic          start_go
);
    a_r2_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bus_grant && bus_req));

    a_r3_step_addr_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (cnt == $past(cnt) - 1'b1) && (mem_addr == $past(mem_addr) + 1'b1));

    a_r5_burst_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !steal && cnt != CW'(1)) |=> bus_req);

    a_r6_steal_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && steal) |=> !bus_req);

    a_r7_last_word_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cnt == CW'(1)) |=> (done && !bus_req));

    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && cnt == '0) |=> (done && !bus_req));
endmodule

bind dma_engine dma_engine_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .cnt       (cur_count),
    .steal     (steal_w),
    .done      (done_w),
    .start_go  (start_go)
);

// File: tb/dma_engine_bench.sv
`timescale 1ns/1ps
module dma_engine_bench;
    localparam int DW = 32, AW = 16, CW = 16, IDW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [2:0]     cfg_addr = '0;
    logic [DW-1:0]  cfg_wdata = '0;
    logic [DW-1:0]  cfg_rdata;
    logic           irq, bus_req, bus_grant;
    logic           mem_en, mem_we, dev_rd, dev_wr;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [IDW-1:0] dev_id;

    dma_engine #(.DW(DW), .AW(AW), .CW(CW), .IDW(IDW)) u_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_id(dev_id),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // bus arbiter stub, memory and device models
    logic        hold_grant = 1'b0;
    logic        clr_mon = 1'b0;
    logic [31:0] mem [64];
    logic [31:0] dev_log [64];
    logic [15:0] dev_rd_cnt;
    int          dev_wr_n, words, falls, run, maxrun, req_cycles, viol;
    logic        prev_req;

    assign mem_rdata = mem[mem_addr[5:0]];
    assign dev_rdata = {16'hDE00, dev_rd_cnt};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_grant  <= 1'b0;
            dev_rd_cnt <= '0;
            dev_wr_n   <= 0;
            for (int i = 0; i < 64; i++) begin
                mem[i]     <= 32'hA500_0000 + i;
                dev_log[i] <= '0;
            end
        end else begin
            bus_grant <= bus_req && !hold_grant;
            if (mem_en && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            if (dev_rd) dev_rd_cnt <= dev_rd_cnt + 1'b1;
            if (dev_wr) begin
                dev_log[dev_wr_n[5:0]] <= dev_wdata;
                dev_wr_n <= dev_wr_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n || clr_mon) begin
            words <= 0; falls <= 0; run <= 0; maxrun <= 0;
            req_cycles <= 0; viol <= 0; prev_req <= 1'b0;
        end else begin
            prev_req <= bus_req;
            if (prev_req && !bus_req) falls <= falls + 1;
            if (bus_req) req_cycles <= req_cycles + 1;
            if ((mem_en || dev_rd || dev_wr) && !(bus_grant && bus_req)) viol <= viol + 1;
            if (mem_en) begin
                words <= words + 1;
                run   <= run + 1;
                if (run + 1 > maxrun) maxrun <= run + 1;
            end else begin
                run <= 0;
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_sel = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); clr_mon = 1'b1;
        @(negedge clk); clr_mon = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(irq == 0 && bus_req == 0 && mem_en == 0 && dev_rd == 0 && dev_wr == 0,
            "R1 reset outputs", {irq, bus_req, mem_en, dev_rd, dev_wr}, 0);
        rd(3'd4, v);
        chk(v == 0, "R1 reset status", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd1, 32'h5A); wr(3'd2, 32'h10); wr(3'd3, 32'd3);
        rd(3'd1, v); chk(v == 32'h5A, "R1 device id readback", v, 32'h5A);
        chk(dev_id == 8'h5A, "R1 dev_id port", dev_id, 8'h5A);
        rd(3'd2, v); chk(v == 32'h10, "R1 address readback", v, 32'h10);
        rd(3'd3, v); chk(v == 32'd3, "R1 count readback", v, 3);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        int base;
        clear_mon();
        base = dev_wr_n;
        wr(3'd0, 32'h9);                    // go, mem->dev, block, irq on
        repeat (20) @(negedge clk);
        chk(words == 3, "R3 burst word count", words, 3);
        chk(viol == 0, "R2 access without grant", viol, 0);
        for (int i = 0; i < 3; i++)
            chk(dev_log[base + i] == 32'hA500_0010 + i, "R4 mem to device data",
                dev_log[base + i], 32'hA500_0010 + i);
        chk(falls == 1 && maxrun == 3, "R5 block holds bus", {falls[15:0], maxrun[15:0]}, 32'h0001_0003);
        chk(irq == 1, "R7 irq raised", irq, 1);
        rd(3'd2, v); chk(v == 32'h13, "R3 final address", v, 32'h13);
        rd(3'd3, v); chk(v == 0, "R3 final count", v, 0);
        rd(3'd4, v); chk(v == 32'h2, "R7 status done not busy", v, 2);
        @(negedge clk);
        chk(irq == 0, "R8 status read clears done", irq, 0);
        rd(3'd4, v); chk(v == 0, "R8 done cleared", v, 0);
    endtask

    task automatic t_steal();
        logic [15:0] base;
        clear_mon();
        base = dev_rd_cnt;
        wr(3'd2, 32'h20); wr(3'd3, 32'd4);
        wr(3'd0, 32'hF);                    // go, dev->mem, steal, irq on
        repeat (30) @(negedge clk);
        chk(words == 4, "R3 steal word count", words, 4);
        chk(viol == 0, "R2 steal access without grant", viol, 0);
        for (int i = 0; i < 4; i++)
            chk(mem[32 + i] == {16'hDE00, base + 16'(i)}, "R4 device to mem data",
                mem[32 + i], {16'hDE00, base + 16'(i)});
        chk(falls == 4 && maxrun == 1, "R6 steal releases bus", {falls[15:0], maxrun[15:0]}, 32'h0004_0001);
        chk(irq == 1, "R7 irq after steal", irq, 1);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        clear_mon();
        hold_grant = 1'b1;
        wr(3'd2, 32'h30); wr(3'd3, 32'd5);
        wr(3'd0, 32'h9);
        repeat (5) @(negedge clk);
        chk(bus_req == 1 && words == 0, "R2 waits for grant", {bus_req, words[7:0]}, 9'h100);
        wr(3'd2, 32'h3A); wr(3'd3, 32'd9); wr(3'd1, 32'h77); wr(3'd0, 32'hF);
        rd(3'd3, v); chk(v == 5, "R9 count write ignored", v, 5);
        rd(3'd2, v); chk(v == 32'h30, "R9 address write ignored", v, 32'h30);
        rd(3'd1, v); chk(v == 32'h5A, "R9 device write ignored", v, 32'h5A);
        rd(3'd4, v); chk(v[0] == 1 && v[1] == 0, "R8 go clears done", v, 1);
        hold_grant = 1'b0;
        repeat (20) @(negedge clk);
        chk(words == 5 && falls == 1, "R9 second go ignored", {words[15:0], falls[15:0]}, 32'h0005_0001);
        rd(3'd2, v); chk(v == 32'h35, "R9 address after block", v, 32'h35);
        rd(3'd4, v);                        // clear done
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(3'd3, 32'd0);
        clear_mon();
        wr(3'd0, 32'h9);
        chk(irq == 1, "R10 zero count done at once", irq, 1);
        repeat (5) @(negedge clk);
        chk(req_cycles == 0 && words == 0, "R10 no bus request", {req_cycles[15:0], words[15:0]}, 0);
        rd(3'd4, v); chk(v == 32'h2, "R10 status done", v, 2);
    endtask

    task automatic t_irq_off();
        logic [31:0] v;
        wr(3'd2, 32'h08); wr(3'd3, 32'd2);
        wr(3'd0, 32'h1);                    // go, block, irq off
        repeat (10) @(negedge clk);
        chk(irq == 0, "R7 irq gated by enable", irq, 0);
        rd(3'd4, v); chk(v == 32'h2, "R7 done without irq", v, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_burst();
        t_steal();
        t_busy_ignore();
        t_zero();
        t_irq_off();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule